// File: doc/BRIEF.md
# Configurable Serial Character Transmitter with Pause Control

This block turns bytes taken from a transmit FIFO into asynchronous serial characters on a single output line. The FIFO storage, the receiver and the baud generator sit outside. The block pops bytes with a read strobe and times every line bit from a one-cycle bit strobe. A format word sets the number of data bits, the parity bit and the number of stop bits. In 9-bit mode one character is built from two consecutive FIFO bytes.

Two pause sources can hold back the next character without cutting the current one short. The first is an active-low clear-to-send input in hardware pause mode. The second is a pair of match pulses from the receiver in software pause mode: one pulse stops transmission and the other resumes it. A non-zero break word drives the line low for as long as it stays set, once any character in progress has finished. When the break word is cleared, the line goes high for at least one bit time before the next character starts.

Top module: `fmt_uart_tx`

## Requirements
- R1: After reset the line is high, `busy` is low and `fifo_rd` is low. The line is high whenever no character and no break is in progress.
- R2: `fmt_cfg[3:0]` sets the data length: 4'b0111 selects 7 bits, 4'b1000 selects 8 bits and 4'b1001 selects 9 bits. Any other code sends 8 bits.
- R3: `fmt_cfg[6:4]` selects the parity bit, which follows the data bits: 3'b000 none, 3'b001 odd, 3'b010 even, 3'b011 always 1, 3'b100 always 0. Codes 3'b101 to 3'b111 send no parity bit. Odd and even parity are computed over the transmitted data bits only.
- R4: `fmt_cfg[7]` = 0 appends one stop bit (high) and `fmt_cfg[7]` = 1 appends two.
- R5: In 9-bit mode the block reads two FIFO bytes. Data bits 7:0 come from the first byte and data bit 8 comes from bit 0 of the second byte. No parity bit is sent, whatever `fmt_cfg[6:4]` holds.
- R6: A character is a low start bit followed by the data bits, least significant first. A character starts on a `bit_tick`, and each line bit lasts from one `bit_tick` to the next.
- R7: While `brk_cfg` is non-zero the line is held low. A character already in progress finishes first. No FIFO byte is read while the break lasts.
- R8: After `brk_cfg` returns to zero the line is high for at least one bit time before the next start bit.
- R9: With `flow_mode` = 3'b001, a high `cts_n` stops new characters from starting, and the character in progress still completes. A low `cts_n` lets transmission continue.
- R10: With `flow_mode` = 3'b010, an `xoff_seen` pulse stops new characters after the current one, and an `xon_seen` pulse resumes them. In every other mode these pulses have no effect, and `cts_n` is ignored in this mode.
- R11: `fifo_rd` is asserted only while `fifo_valid` is high, and each byte is read exactly once.
- R12: `busy` is high from the cycle after the first byte of a character is read until the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| fifo_data | input | 8 | Byte at the head of the transmit FIFO |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_rd | output | 1 | Pops the head byte in this cycle |
| fmt_cfg | input | 8 | Format word: length code [3:0], parity [6:4], stop count [7] |
| flow_mode | input | 3 | Pause mode: 000 none, 001 clear-to-send, 010 match pulses |
| brk_cfg | input | 8 | Non-zero requests a continuous break |
| cts_n | input | 1 | Active-low clear-to-send |
| xon_seen | input | 1 | Receiver matched the resume character |
| xoff_seen | input | 1 | Receiver matched the stop character |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A character is being assembled or shifted |

## Verification
The assertions rely on the following input assumptions:
- `fifo_data` is steady while `fifo_valid` is high and no read occurs.
- `cts_n` is already synchronous to `clk`.
- `bit_tick` pulses for single cycles.
- The format word does not change between the two reads of a 9-bit character.

The bench keeps to these assumptions in the following ways:
- It models the FIFO as an array with pointers that move only on `fifo_rd`.
- It produces `bit_tick` from a free-running divide-by-four counter.
- It drives every control input at falling edges, and sets the format word before the bytes of a character are pushed.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 12;

  localparam logic [3:0] LEN7_CODE = 4'b0111;
  localparam logic [3:0] LEN9_CODE = 4'b1001;

  localparam logic [2:0] PAR_ODD   = 3'b001;
  localparam logic [2:0] PAR_EVEN  = 3'b010;
  localparam logic [2:0] PAR_MARK  = 3'b011;
  localparam logic [2:0] PAR_SPACE = 3'b100;

  localparam logic [2:0] FLOW_HW = 3'b001;
  localparam logic [2:0] FLOW_SW = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HIGH_BYTE, ST_ARMED, ST_SHIFT, ST_BREAK, ST_GAP
  } tx_state_e;

  // number of data bits selected by the length code
  function automatic logic [3:0] data_len(input logic [3:0] code);
    case (code)
      LEN7_CODE: data_len = 4'd7;
      LEN9_CODE: data_len = 4'd9;
      default:   data_len = 4'd8;
    endcase
  endfunction

  function automatic logic has_parity(input logic [7:0] fmt);
    has_parity = (data_len(fmt[3:0]) != 4'd9) && (fmt[6:4] != 3'b000) && (fmt[6:4] <= PAR_SPACE);
  endfunction

  function automatic logic parity_bit(input logic [8:0] d, input logic [3:0] n, input logic [2:0] sel);
    logic x;
    x = (n == 4'd7) ? ^d[6:0] : ^d[7:0];
    case (sel)
      PAR_ODD:  parity_bit = ~x;
      PAR_EVEN: parity_bit = x;
      PAR_MARK: parity_bit = 1'b1;
      default:  parity_bit = 1'b0;
    endcase
  endfunction

  // total line bits: start + data + parity + stop
  function automatic logic [3:0] frame_len(input logic [7:0] fmt);
    frame_len = 4'd1 + data_len(fmt[3:0]) + {3'b000, has_parity(fmt)} + (fmt[7] ? 4'd2 : 4'd1);
  endfunction

  // line bits in send order at index 0 upward; unused upper bits stay high
  function automatic logic [FRAME_W-1:0] build_frame(input logic [8:0] d, input logic [7:0] fmt);
    logic [FRAME_W-1:0] f;
    logic [3:0] n;
    n = data_len(fmt[3:0]);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (4'(i) < n) f[i+1] = d[i];
    end
    if (has_parity(fmt)) f[n + 4'd1] = parity_bit(d, n, fmt[6:4]);
    build_frame = f;
  endfunction
endpackage

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] flow_mode,
  input  logic       cts_n,
  input  logic       xon_seen,
  input  logic       xoff_seen,
  output logic       may_send
);
  logic sw_hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     sw_hold_q <= 1'b0;
    else if (flow_mode != FLOW_SW)  sw_hold_q <= 1'b0;
    else if (xoff_seen && !xon_seen) sw_hold_q <= 1'b1;
    else if (xon_seen && !xoff_seen) sw_hold_q <= 1'b0;
  end

  always_comb begin
    case (flow_mode)
      FLOW_HW: may_send = !cts_n;
      FLOW_SW: may_send = !sw_hold_q;
      default: may_send = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_rd,
  input  logic [7:0]        fmt_cfg,
  input  logic              brk_on,
  input  logic              may_send,
  output logic              txd,
  output logic              busy,
  output logic              in_break,
  output logic              shifting,
  output logic              frame_start
);
  localparam int CNT_W = $clog2(FRAME_W);

  tx_state_e          state_q;
  logic [BYTE_W-1:0]  lo_q;
  logic               hi_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               nine_sel;

  assign nine_sel = (data_len(fmt_cfg[3:0]) == 4'd9);

  always_comb begin
    fifo_rd = 1'b0;
    if (state_q == ST_IDLE)      fifo_rd = !brk_on && may_send && fifo_valid;
    if (state_q == ST_HIGH_BYTE) fifo_rd = fifo_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= 1'b0;
      sh_q    <= '1;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (brk_on) state_q <= ST_BREAK;
          else if (fifo_rd) begin
            lo_q    <= fifo_data;
            hi_q    <= 1'b0;
            state_q <= nine_sel ? ST_HIGH_BYTE : ST_ARMED;
          end
        end
        ST_HIGH_BYTE: begin
          if (fifo_valid) begin
            hi_q    <= fifo_data[0];
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (bit_tick) begin
            sh_q    <= build_frame({hi_q, lo_q}, fmt_cfg);
            cnt_q   <= CNT_W'(frame_len(fmt_cfg) - 4'd1);
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_tick) begin
            if (cnt_q == '0) state_q <= ST_IDLE;
            else begin
              sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        ST_BREAK: if (bit_tick && !brk_on) state_q <= ST_GAP;
        ST_GAP:   if (bit_tick) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign shifting    = (state_q == ST_SHIFT);
  assign in_break    = (state_q == ST_BREAK);
  assign frame_start = (state_q == ST_ARMED) && bit_tick;
  assign busy        = (state_q == ST_HIGH_BYTE) || (state_q == ST_ARMED) || shifting;
  assign txd         = shifting ? sh_q[0] : !in_break;
endmodule

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int BRK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_rd,
  input  logic [7:0]        fmt_cfg,
  input  logic [2:0]        flow_mode,
  input  logic [BRK_W-1:0]  brk_cfg,
  input  logic              cts_n,
  input  logic              xon_seen,
  input  logic              xoff_seen,
  output logic              txd,
  output logic              busy
);
  logic may_send;
  logic in_break;
  logic shifting;
  logic frame_start;
  logic brk_on;

  assign brk_on = |brk_cfg;

  uart_tx_flow u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_mode (flow_mode),
    .cts_n     (cts_n),
    .xon_seen  (xon_seen),
    .xoff_seen (xoff_seen),
    .may_send  (may_send)
  );

  uart_tx_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .fifo_data   (fifo_data),
    .fifo_valid  (fifo_valid),
    .fifo_rd     (fifo_rd),
    .fmt_cfg     (fmt_cfg),
    .brk_on      (brk_on),
    .may_send    (may_send),
    .txd         (txd),
    .busy        (busy),
    .in_break    (in_break),
    .shifting    (shifting),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/fmt_uart_tx_chk.sv
module fmt_uart_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       fifo_valid,
  input logic       fifo_rd,
  input logic [2:0] flow_mode,
  input logic       cts_n,
  input logic       txd,
  input logic       busy,
  input logic       may_send,
  input logic       in_break,
  input logic       shifting,
  input logic       frame_start
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_break) |-> txd);

  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd);

  a_r7_break_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !fifo_rd);

  a_r8_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_break) |-> txd);

  a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !txd);

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && $past(shifting) && !$past(bit_tick)) |-> $stable(txd));

  a_r9_cts_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode == 3'b001 && cts_n && !busy) |-> !fifo_rd);

  a_r10_match_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode == 3'b010 && !may_send && !busy) |-> !fifo_rd);

  a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_valid);

  a_r12_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> busy);
endmodule

bind fmt_uart_tx fmt_uart_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .fifo_valid  (fifo_valid),
  .fifo_rd     (fifo_rd),
  .flow_mode   (flow_mode),
  .cts_n       (cts_n),
  .txd         (txd),
  .busy        (busy),
  .may_send    (may_send),
  .in_break    (in_break),
  .shifting    (shifting),
  .frame_start (frame_start)
);

// File: tb/fmt_uart_tx_test.sv
module fmt_uart_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       bit_tick;
  logic [7:0] fifo_data;
  logic       fifo_valid;
  logic       fifo_rd;
  logic [7:0] fmt_cfg = 8'h08;
  logic [2:0] flow_mode = 3'b000;
  logic [7:0] brk_cfg = 8'h00;
  logic       cts_n = 1'b0;
  logic       xon_seen = 1'b0;
  logic       xoff_seen = 1'b0;
  logic       txd;
  logic       busy;

  logic [7:0] qmem [0:255];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end

  assign bit_tick   = (tdiv == 2'd3);
  assign fifo_valid = (rd_ptr < wr_ptr);
  assign fifo_data  = qmem[rd_ptr % 256];

  fmt_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_rd(fifo_rd),
    .fmt_cfg(fmt_cfg), .flow_mode(flow_mode), .brk_cfg(brk_cfg),
    .cts_n(cts_n), .xon_seen(xon_seen), .xoff_seen(xoff_seen),
    .txd(txd), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    qmem[wr_ptr % 256] = b;
    wr_ptr = wr_ptr + 1;
  endtask

  // expected line bits, computed by counting ones
  function automatic int frame_expect(input logic [7:0] f, input logic [8:0] d, output logic [15:0] b);
    int nd, k, ones;
    nd = (f[3:0] == 4'b0111) ? 7 : (f[3:0] == 4'b1001) ? 9 : 8;
    b = 16'hFFFF;
    b[0] = 1'b0;
    k = 1;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      b[k] = d[i];
      if (d[i]) ones++;
      k++;
    end
    if (nd != 9) begin
      case (f[6:4])
        3'd1: begin b[k] = (ones % 2 == 0); k++; end
        3'd2: begin b[k] = (ones % 2 == 1); k++; end
        3'd3: begin b[k] = 1'b1; k++; end
        3'd4: begin b[k] = 1'b0; k++; end
        default: ;
      endcase
    end
    k = k + (f[7] ? 2 : 1);
    return k;
  endfunction

  // act: 0 none, 1 xoff pulse, 2 raise cts_n, 3 set break
  task automatic find_start(input int act);
    do @(negedge clk); while (txd !== 1'b0);
    if (act == 1) xoff_seen = 1'b1;
    if (act == 2) cts_n = 1'b1;
    if (act == 3) brk_cfg = 8'h04;
    @(negedge clk);
    xoff_seen = 1'b0;
    @(negedge clk);
  endtask

  task automatic sample_rest(input int n, output logic [15:0] got);
    got = 16'h0;
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (4) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic recv_check(input logic [7:0] f, input logic [8:0] d, input int act, input string req);
    logic [15:0] e, g, m;
    int n;
    n = frame_expect(f, d, e);
    find_start(act);
    sample_rest(n, g);
    m = (16'd1 << n) - 16'd1;
    chk((g & m) == (e & m), req, "frame bits", int'(g & m), int'(e & m));
  endtask

  task automatic send_check(input logic [7:0] f, input logic [7:0] lo, input logic hi, input string req);
    fmt_cfg = f;
    push(lo);
    if (f[3:0] == 4'b1001) push({7'h7F, hi});
    recv_check(f, {hi, lo}, 0, req);
  endtask

  task automatic count_low(input int cyc, output int lows);
    lows = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
  endtask

  task automatic pulse_xon();
    @(negedge clk); xon_seen = 1'b1;
    @(negedge clk); xon_seen = 1'b0;
  endtask

  task automatic pulse_xoff();
    @(negedge clk); xoff_seen = 1'b1;
    @(negedge clk); xoff_seen = 1'b0;
  endtask

  initial begin
    int lows, highs;
    logic [15:0] e, g, m;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1", "idle line", int'(txd), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(fifo_rd == 1'b0, "R1", "read after reset", int'(fifo_rd), 0);

    // 7 and 8 bit lengths, all parity codes, both stop counts
    for (int L = 0; L < 2; L++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s < 2; s++)
          send_check({s[0], p[2:0], (L == 0) ? 4'b0111 : 4'b1000},
                     8'hA5 ^ 8'(p * 29 + s * 7 + L * 64), 1'b0, "R2 R3 R4 R6");

    // reserved length and parity codes
    send_check(8'b0_101_0000, 8'hC3, 1'b0, "R2 R3");
    send_check(8'b1_111_1111, 8'h3C, 1'b0, "R2 R3");

    // 9-bit characters: parity field ignored, bit 8 from second byte
    for (int p = 0; p < 5; p++)
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 2; h++)
          send_check({s[0], p[2:0], 4'b1001}, 8'h5A ^ 8'(p * 13 + h * 3), h[0], "R5");

    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R12", "busy when drained", int'(busy), 0);
    chk(rd_ptr == wr_ptr, "R11", "bytes read", rd_ptr, wr_ptr);

    // busy while shifting
    fmt_cfg = 8'h08;
    push(8'h81);
    find_start(0);
    chk(busy == 1'b1, "R12", "busy in start bit", int'(busy), 1);
    sample_rest(frame_expect(8'h08, 9'h081, e), g);

    // hardware pause
    flow_mode = 3'b001;
    cts_n = 1'b1;
    push(8'h3C);
    count_low(60, lows);
    chk(lows == 0, "R9", "line low while paused", lows, 0);
    chk(wr_ptr - rd_ptr == 1, "R9", "pending bytes", wr_ptr - rd_ptr, 1);
    cts_n = 1'b0;
    recv_check(8'h08, 9'h03C, 0, "R9");
    push(8'h96);
    push(8'h69);
    recv_check(8'h08, 9'h096, 2, "R9");
    count_low(80, lows);
    chk(lows == 0, "R9", "line low after mid-char pause", lows, 0);
    chk(wr_ptr - rd_ptr == 1, "R9", "pending after pause", wr_ptr - rd_ptr, 1);
    cts_n = 1'b0;
    recv_check(8'h08, 9'h069, 0, "R9");

    // match-pulse pause; cts_n high must not matter here
    flow_mode = 3'b010;
    cts_n = 1'b1;
    pulse_xoff();
    push(8'hE7);
    count_low(60, lows);
    chk(lows == 0, "R10", "line low after stop pulse", lows, 0);
    chk(wr_ptr - rd_ptr == 1, "R10", "pending after stop pulse", wr_ptr - rd_ptr, 1);
    pulse_xon();
    recv_check(8'h08, 9'h0E7, 0, "R10");
    push(8'h12);
    push(8'h34);
    recv_check(8'h08, 9'h012, 1, "R10");
    count_low(80, lows);
    chk(lows == 0, "R10", "line low after mid-char stop", lows, 0);
    chk(wr_ptr - rd_ptr == 1, "R10", "pending after mid-char stop", wr_ptr - rd_ptr, 1);
    pulse_xon();
    recv_check(8'h08, 9'h034, 0, "R10");

    // pulses ignored without pause mode
    flow_mode = 3'b000;
    cts_n = 1'b0;
    pulse_xoff();
    push(8'h77);
    recv_check(8'h08, 9'h077, 0, "R10");

    // break waits for the character, then holds the line low
    push(8'h5A);
    recv_check(8'h08, 9'h05A, 3, "R7");
    repeat (4) @(negedge clk);
    chk(txd == 1'b0, "R7", "line in break", int'(txd), 0);
    push(8'hB4);
    count_low(40, lows);
    chk(lows == 40, "R7", "low samples in break", lows, 40);
    chk(wr_ptr - rd_ptr == 1, "R7", "bytes read in break", wr_ptr - rd_ptr, 1);
    brk_cfg = 8'h00;
    while (txd == 1'b0) @(negedge clk);
    highs = 0;
    do begin highs++; @(negedge clk); end while (txd == 1'b1);
    chk(highs >= 4, "R8", "high samples after break", highs, 4);
    repeat (2) @(negedge clk);
    n = frame_expect(8'h08, 9'h0B4, e);
    sample_rest(n, g);
    m = (16'd1 << n) - 16'd1;
    chk((g & m) == (e & m), "R8", "frame after break", int'(g & m), int'(e & m));

    repeat (8) @(negedge clk);
    chk(txd == 1'b1, "R1", "idle at end", int'(txd), 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule